// File: doc/BRIEF.md
# Register Interlock Scoreboard

This block keeps one lock bit for each architectural register of an in-order, five-stage pipeline: fetch, decode, operand fetch, execute, write-back. A lock bit of 1 means the register's contents must not be used yet. A lock bit of 0 means they may be read. When an instruction that writes a register issues, the block locks that register. When the result of that instruction is written back, the block unlocks it. An instruction sitting in operand fetch whose sources name a locked register sees the stall output high. The pipeline holds that instruction until the lock is released.

Every read-after-write dependency is resolved from the lock bits alone. No comparators are placed on the pipeline stages. The block therefore also covers cases where the value exists nowhere in the pipeline yet, such as an add that reads a register a load is still filling. A producer issued in cycle 1 keeps its destination locked through operand fetch, execute and write-back (cycles 3 to 5). A longer-latency producer keeps the lock for as many cycles as it needs.

Register 0 is treated as a constant and is never locked, so a source index of 0 also serves as "no source". Forwarding and the register file datapath are outside this block.

Top module: `regilock_sb`

## Requirements
- R1: An active-low reset, asynchronous, clears every lock bit.
- R2: When `iss_vld` and `iss_wen` are both 1 at a rising edge, the bit of register `iss_dst` reads 1 on `lock_vec` after that edge.
- R3: An issue with `iss_wen` = 0, or with `iss_vld` = 0, changes no lock bit.
- R4: When `wb_vld` is 1 at a rising edge, the bit of register `wb_idx` reads 0 after that edge.
- R5: A lock bit that is neither set nor cleared keeps its value for any number of cycles, so a slow producer such as a load keeps its reader stalled.
- R6: `stall` is 1 in the same cycle when either `src_a` or `src_b` names a register whose lock bit is 1, except as stated in R7.
- R7: A source whose register is being written back in the current cycle (`wb_vld` = 1 and `wb_idx` equal to that source) is treated as unlocked and does not cause a stall.
- R8: When an issue locks a register in the same cycle a write-back releases that same register, the bit reads 1 afterwards.
- R9: Register 0 never locks, and a source of 0 never stalls.
- R10: Sources that name only unlocked registers never stall. This holds when both sources name the same register, and when other registers are locked.
- R11: In one cycle, an issue to one register and a write-back of a different register both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | An instruction issues this cycle |
| iss_dst | input | IDXW | Destination register of the issuing instruction |
| iss_wen | input | 1 | The issuing instruction writes its destination |
| src_a | input | IDXW | First source register of the instruction in operand fetch |
| src_b | input | IDXW | Second source register of the instruction in operand fetch |
| wb_vld | input | 1 | A result is written back this cycle |
| wb_idx | input | IDXW | Register receiving the write-back |
| stall | output | 1 | Hold the instruction in operand fetch |
| lock_vec | output | NREG | Current lock bit of every register, bit i for register i |

## Verification
The bench uses an eight-register configuration. It locks each nonzero register in turn. For each lock, it sweeps every pair of source indices. This separates stalls caused by the locked register from the no-stall cases: both sources naming the same unlocked register, and register 0. A long run of idle cycles with a locked source checks that the stall lasts until write-back, however long the producer takes.

Targeted same-cycle patterns cover three cases: a write-back meeting a reader, a write-back meeting a new producer on the same register, and a write-back and an issue on different registers. These show the order of set and clear, and the read bypass. Issues with the write enable or the valid low, issues to register 0, and a reset in the middle of a run show which stimuli must leave the lock vector untouched.

// File: rtl/regilock_pkg.sv
package regilock_pkg;
   // Selects how register 0 behaves in the lock array
   typedef enum logic [0:0] {
      ZERO_FIXED    = 1'b0,
      ZERO_LOCKABLE = 1'b1
   } zero_mode_e;
endpackage

// File: rtl/regilock_dec.sv
module regilock_dec #(
   parameter int NREG = 32,
   parameter int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic            en,
   input  logic [IDXW-1:0] idx,
   output logic [NREG-1:0] onehot
);
   always_comb begin
      onehot = '0;
      for (int i = 0; i < NREG; i++) begin
         if (en && (idx == IDXW'(i))) onehot[i] = 1'b1;
      end
   end
endmodule

// File: rtl/regilock_bits.sv
module regilock_bits
   import regilock_pkg::*;
#(
   parameter int         NREG      = 32,
   parameter zero_mode_e ZERO_MODE = ZERO_FIXED
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREG-1:0] set_vec,
   input  logic [NREG-1:0] clr_vec,
   output logic [NREG-1:0] lock_q
);
   localparam logic [NREG-1:0] LOCKABLE =
      (ZERO_MODE == ZERO_FIXED) ? {{(NREG-1){1'b1}}, 1'b0} : {NREG{1'b1}};

   // set is applied after clear: a new producer wins over an older write-back
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q <= '0;
      else        lock_q <= ((lock_q & ~clr_vec) | set_vec) & LOCKABLE;
   end

   // R5
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec == '0) && (clr_vec == '0)) |=> $stable(lock_q));

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec & LOCKABLE) != '0) |=> ((lock_q & $past(set_vec & LOCKABLE)) == $past(set_vec & LOCKABLE)));
endmodule

// File: rtl/regilock_hazard.sv
module regilock_hazard #(
   parameter int NREG = 32
) (
   input  logic [NREG-1:0] lock_q,
   input  logic [NREG-1:0] clr_vec,
   input  logic [NREG-1:0] sel_a,
   input  logic [NREG-1:0] sel_b,
   output logic            stall
);
   logic [NREG-1:0] eff_lock;
   logic            hit_a, hit_b;

   // a register released this cycle is already readable
   assign eff_lock = lock_q & ~clr_vec;
   assign hit_a    = |(sel_a & eff_lock);
   assign hit_b    = |(sel_b & eff_lock);
   assign stall    = hit_a | hit_b;
endmodule

// File: rtl/regilock_sb.sv
module regilock_sb
   import regilock_pkg::*;
#(
   parameter int         NREG      = 32,
   parameter zero_mode_e ZERO_MODE = ZERO_FIXED,
   parameter int         IDXW      = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            iss_vld,
   input  logic [IDXW-1:0] iss_dst,
   input  logic            iss_wen,
   input  logic [IDXW-1:0] src_a,
   input  logic [IDXW-1:0] src_b,
   input  logic            wb_vld,
   input  logic [IDXW-1:0] wb_idx,
   output logic            stall,
   output logic [NREG-1:0] lock_vec
);
   generate
      if (NREG < 2) begin : g_bad_nreg
         $error("regilock_sb: NREG must be at least 2");
      end
      if ((1 << IDXW) < NREG) begin : g_bad_idxw
         $error("regilock_sb: IDXW too narrow for NREG");
      end
   endgenerate

   logic [NREG-1:0] set_vec, clr_vec, sel_a, sel_b;

   regilock_dec #(.NREG(NREG), .IDXW(IDXW)) u_dec_set (
      .en(iss_vld & iss_wen), .idx(iss_dst), .onehot(set_vec));
   regilock_dec #(.NREG(NREG), .IDXW(IDXW)) u_dec_clr (
      .en(wb_vld), .idx(wb_idx), .onehot(clr_vec));
   regilock_dec #(.NREG(NREG), .IDXW(IDXW)) u_dec_a (
      .en(1'b1), .idx(src_a), .onehot(sel_a));
   regilock_dec #(.NREG(NREG), .IDXW(IDXW)) u_dec_b (
      .en(1'b1), .idx(src_b), .onehot(sel_b));

   regilock_bits #(.NREG(NREG), .ZERO_MODE(ZERO_MODE)) u_bits (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
      .lock_q(lock_vec));

   regilock_hazard #(.NREG(NREG)) u_haz (
      .lock_q(lock_vec), .clr_vec(clr_vec), .sel_a(sel_a), .sel_b(sel_b),
      .stall(stall));

   // R2
   lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_vld && iss_wen && (iss_dst != '0)) |=> lock_vec[$past(iss_dst)]);

   // R4
   lock_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_vld && !(iss_vld && iss_wen && (iss_dst == wb_idx))) |=> !lock_vec[$past(wb_idx)]);

   // R10
   idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_vec == '0) |-> !stall);

   // R9
   zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_a == '0) && (src_b == '0) && (ZERO_MODE == ZERO_FIXED)) |-> !stall);

   // R7
   wb_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_vld && (src_a == wb_idx) && (src_b == wb_idx)) |-> !stall);
endmodule

// File: tb/regilock_sb_bench.sv
module regilock_sb_bench;
   localparam int N = 8;
   localparam int W = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         iss_vld = 1'b0, iss_wen = 1'b0, wb_vld = 1'b0;
   logic [W-1:0] iss_dst = '0, src_a = '0, src_b = '0, wb_idx = '0;
   logic         stall;
   logic [N-1:0] lock_vec;
   logic [N-1:0] mdl = '0;
   int           nrun = 0, nfail = 0;

   always #5 clk = ~clk;

   regilock_sb #(.NREG(N)) u_regilock_sb (
      .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_dst(iss_dst),
      .iss_wen(iss_wen), .src_a(src_a), .src_b(src_b), .wb_vld(wb_vld),
      .wb_idx(wb_idx), .stall(stall), .lock_vec(lock_vec));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nrun++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit src_locked(input int s, input bit wv, input int wi);
      return (s != 0) && mdl[s] && !(wv && (wi == s));
   endfunction

   // drive one cycle at negedge, check stall before the edge, lock_vec after
   task automatic cyc(input bit iv, input int id, input bit iw, input int a, input int b,
                      input bit wv, input int wi, input string rs, input string rl);
      bit es;
      iss_vld = iv; iss_dst = W'(id); iss_wen = iw;
      src_a = W'(a); src_b = W'(b); wb_vld = wv; wb_idx = W'(wi);
      #1;
      es = src_locked(a, wv, wi) || src_locked(b, wv, wi);
      chk(stall == es, rs, 32'(stall), 32'(es));
      @(posedge clk);
      if (wv) mdl[wi] = 1'b0;
      if (iv && iw && id != 0) mdl[id] = 1'b1;
      @(negedge clk);
      chk(lock_vec == mdl, rl, 32'(lock_vec), 32'(mdl));
   endtask

   initial begin
      repeat (2) @(negedge clk);
      chk(lock_vec == '0, "R1", 32'(lock_vec), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // sweep: lock each register, try every source pair
      for (int r = 1; r < N; r++) begin
         cyc(1, r, 1, 0, 0, 0, 0, "R9", "R2");
         for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++)
               cyc(0, 0, 0, a, b, 0, 0, "R6/R10", "R5");
         cyc(0, 0, 0, 0, 0, 1, r, "R9", "R4");
      end

      // no write enable / no valid
      cyc(1, 3, 0, 3, 3, 0, 0, "R10", "R3");
      cyc(0, 4, 1, 4, 4, 0, 0, "R10", "R3");
      cyc(0, 0, 0, 3, 4, 0, 0, "R3", "R3");

      // write-back bypass to a reader
      cyc(1, 5, 1, 0, 0, 0, 0, "R9", "R2");
      cyc(0, 0, 0, 5, 0, 0, 0, "R6", "R5");
      cyc(0, 0, 0, 5, 5, 1, 5, "R7", "R4");

      // same-register set and clear
      cyc(1, 2, 1, 0, 0, 0, 0, "R9", "R2");
      cyc(1, 2, 1, 2, 0, 1, 2, "R7", "R8");
      cyc(0, 0, 0, 0, 2, 0, 0, "R8", "R8");
      cyc(0, 0, 0, 0, 0, 1, 2, "R9", "R4");

      // register 0
      cyc(1, 0, 1, 0, 0, 0, 0, "R9", "R9");
      cyc(0, 0, 0, 0, 0, 0, 0, "R9", "R9");

      // independent set and clear
      cyc(1, 1, 1, 0, 0, 0, 0, "R9", "R2");
      cyc(1, 6, 1, 1, 6, 0, 0, "R6", "R2");
      cyc(1, 3, 1, 1, 6, 1, 1, "R11", "R11");
      cyc(0, 0, 0, 1, 4, 0, 0, "R10", "R11");

      // slow producer keeps its reader stalled
      cyc(1, 7, 1, 0, 0, 0, 0, "R9", "R2");
      for (int k = 0; k < 20; k++) cyc(0, 0, 0, 7, 2, 0, 0, "R5", "R5");
      cyc(0, 0, 0, 7, 2, 1, 7, "R7", "R4");

      // reset in the middle of a run
      rst_n = 1'b0;
      #1;
      chk(lock_vec == '0, "R1", 32'(lock_vec), 0);
      mdl = '0;
      @(negedge clk);
      rst_n = 1'b1;
      cyc(0, 0, 0, 3, 6, 0, 0, "R1", "R1");

      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
   end
endmodule